// File: doc/BRIEF.md
# Serial Converter Frame Controller

This block is the synchronous control logic of a four-channel, 10-bit serial analog-to-digital converter. It runs on a fast system clock, synchronizes the active-low chip select, the serial clock and the serial data input, and recovers their edges. Chip select low frames a transfer. Inside a frame the block counts serial clock edges in 16-cycle conversions and sequences tracking, hold/convert and automatic power-down. It collects a control byte whose channel field picks the input for the *following* conversion, and shifts a result word out MSB first with an output-enable for a tri-state pad.

The analog side stays outside. The block presents the channel of the conversion in progress on `conv_chan_o`, and the front end answers with a parallel 10-bit code on `result_i`. That code is captured at the instant hold begins. The serial clock is gated while chip select is high. If the serial clock idles low, the fall of chip select is itself the first falling edge of the frame.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: Each conversion spans exactly 16 serial clock cycles. Cycle n begins at the n-th falling edge of the gated serial clock. Conversions follow one another without a gap for as long as chip select stays low.
- R2: `sdo_en_o` is 0 while chip select is high and 1 while it is low.
- R3: The 16-bit word on `sdo_o` holds 0 in positions 1 to 4, the captured code MSB first in positions 5 to 14, and 0 in positions 15 and 16. Position n is driven after the n-th falling edge of the conversion.
- R4: The control byte is taken from `sdi_i` on the first 8 rising edges of each conversion, MSB first. Byte bits 4:3 select the channel: 00 for input 0, 01 for input 1, 10 for input 2, 11 for input 3. Bits 7:5 and 2:0 have no effect.
- R5: A channel loaded during one conversion applies to the next conversion, including one in a later frame. The first conversion after reset uses input 0, and `conv_chan_o` shows the channel being converted.
- R6: `track_o` is 1 during cycles 1 to 3 of every conversion. It drops at the 4th falling edge, where hold/convert begins.
- R7: `pdn_o` is 1 while chip select is high, and from the 16th falling edge of a conversion until the first falling edge of the next one.
- R8: If the serial clock is low when chip select falls, that fall counts as the first falling edge. If it is high, the first real falling edge after chip select falls counts.
- R9: Reset clears the edge counter, sets the pending channel to input 0, and leaves `sdo_en_o` and `sdo_o` at 0.
- R10: `result_i` is sampled once, at the 4th falling edge. Changes to it later in the same conversion do not alter the word that is shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, frames the transfer |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial control data |
| result_i | input | 10 | Conversion code from the analog front end |
| sdo_o | output | 1 | Serial result data |
| sdo_en_o | output | 1 | Output enable for the tri-state data pad |
| conv_chan_o | output | 2 | Channel of the conversion in progress |
| track_o | output | 1 | High while the input is being tracked |
| pdn_o | output | 1 | High while the converter is powered down |

## Verification
The assertions rely on a few properties of the inputs. Each serial clock half period must outlast the synchronizer and edge-detect latency of about four system clocks. Chip select must not change in the same system clock as a serial clock edge. Serial data must be stable across each rising edge. The stimulus keeps within these by moving every pin on a falling system clock edge, holding each serial clock level for eight system clocks, changing `sdi_i` one half period before the rising edge, and keeping every frame a whole number of conversions. Both idle levels of the serial clock are used. One conversion deliberately alters `result_i` after hold begins.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_HOLD  = 2'd2,
    PH_REST  = 2'd3
  } phase_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= RST_VAL;
      else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int WORD_LEN  = 16,
  parameter int TRACK_CYC = 3,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pos_nxt_o,
  output logic             conv_start_o,
  output logic             track_o,
  output logic             pdn_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_LEN);
  localparam logic [CNT_W-1:0] TEND = CNT_W'(TRACK_CYC);

  logic [CNT_W-1:0] cnt_q, pos_nxt;
  logic             wrap;
  phase_e           ph_q, ph_nxt;

  always_comb begin
    wrap = (cnt_q == '0) || (cnt_q == LAST);
    if (!active_i)   pos_nxt = '0;
    else if (fall_i) pos_nxt = wrap ? CNT_W'(1) : cnt_q + CNT_W'(1);
    else             pos_nxt = cnt_q;

    if (pos_nxt == '0)        ph_nxt = PH_IDLE;
    else if (pos_nxt <= TEND) ph_nxt = PH_TRACK;
    else if (pos_nxt == LAST) ph_nxt = PH_REST;
    else                      ph_nxt = PH_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= PH_IDLE;
    end else begin
      cnt_q <= pos_nxt;
      ph_q  <= ph_nxt;
    end
  end

  assign cnt_o        = cnt_q;
  assign pos_nxt_o    = pos_nxt;
  assign conv_start_o = active_i && fall_i && wrap;
  assign track_o      = (ph_q == PH_TRACK);
  assign pdn_o        = (ph_q == PH_IDLE) || (ph_q == PH_REST);

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  a_r1_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (active_i && fall_i && cnt_q != '0 && cnt_q != LAST) |=>
      (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r7_idle_pd: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (pdn_o && !track_o));
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
  parameter int CTRL_BITS = 8,
  parameter int SEL_LSB   = 3,
  parameter int CH_W      = 2,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sdi_i,
  input  logic             conv_start_i,
  output logic [CH_W-1:0]  chan_o
);
  // field bit j (MSB-first byte) arrives on rising edge CTRL_BITS-j
  localparam logic [CNT_W-1:0] R_LO  = CNT_W'(CTRL_BITS - (SEL_LSB + CH_W - 1));
  localparam logic [CNT_W-1:0] R_HI  = CNT_W'(CTRL_BITS - SEL_LSB);
  localparam logic [CNT_W-1:0] R_END = CNT_W'(CTRL_BITS);

  logic [CH_W-1:0] field_q, pend_q, cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= '0;
      pend_q  <= '0;
      cur_q   <= '0;
    end else begin
      if (rise_i && cnt_i >= R_LO && cnt_i <= R_HI)
        field_q <= CH_W'({field_q, sdi_i});
      if (rise_i && cnt_i == R_END)
        pend_q <= field_q;
      if (conv_start_i)
        cur_q <= pend_q;
    end
  end

  assign chan_o = cur_q;

  a_r4_late_commit: assert property (@(posedge clk) disable iff (rst)
    !(rise_i && cnt_i == R_END) |=> $stable(pend_q));
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int DATA_W = 10,
  parameter int LEAD   = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  pos_nxt_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  localparam logic [CNT_W-1:0] P_CAP = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] P_LO  = CNT_W'(LEAD + 1);
  localparam logic [CNT_W-1:0] P_HI  = CNT_W'(LEAD + DATA_W);

  logic [DATA_W-1:0] word_q;
  logic              sdo_q, en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sdo_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= active_i;
      if (!active_i) begin
        sdo_q <= 1'b0;
      end else if (fall_i) begin
        if (pos_nxt_i == P_CAP) begin
          word_q <= result_i;
          sdo_q  <= 1'b0;
        end else if (pos_nxt_i >= P_LO && pos_nxt_i <= P_HI) begin
          sdo_q  <= word_q[DATA_W-1];
          word_q <= {word_q[DATA_W-2:0], 1'b0};
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = en_q;

  a_r3_zero_pad: assert property (@(posedge clk) disable iff (rst)
    !(cnt_i >= P_LO && cnt_i <= P_HI) |-> !sdo_q);
  a_r10_word_frozen: assert property (@(posedge clk) disable iff (rst)
    (!fall_i && active_i) |=> $stable(word_q));
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl #(
  parameter int DATA_W      = 10,
  parameter int CH_W        = 2,
  parameter int WORD_LEN    = 16,
  parameter int TRACK_CYC   = 3,
  parameter int CTRL_BITS   = 8,
  parameter int SEL_LSB     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic              track_o,
  output logic              pdn_o
);
  localparam int CNT_W = $clog2(WORD_LEN + 1);
  localparam int LEAD  = TRACK_CYC + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_LEN);

  logic [2:0]       pins_s;
  logic             cs_s, sclk_s, sdi_s;
  logic             gclk, gclk_d, active, fall, rise;
  logic [CNT_W-1:0] cnt, pos_nxt;
  logic             conv_start;

  sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n_i, sclk_i, sdi_i}),
    .q   (pins_s)
  );
  assign {cs_s, sclk_s, sdi_s} = pins_s;

  // serial clock held high while deselected: a low clock makes CS fall an edge
  assign gclk   = sclk_s | cs_s;
  assign active = !cs_s;

  always_ff @(posedge clk) begin
    if (rst) gclk_d <= 1'b1;
    else     gclk_d <= gclk;
  end

  assign fall = gclk_d && !gclk;
  assign rise = !gclk_d && gclk && active;

  sadc_seq #(.WORD_LEN(WORD_LEN), .TRACK_CYC(TRACK_CYC), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .active_i     (active),
    .fall_i       (fall),
    .cnt_o        (cnt),
    .pos_nxt_o    (pos_nxt),
    .conv_start_o (conv_start),
    .track_o      (track_o),
    .pdn_o        (pdn_o)
  );

  sadc_ctrl #(.CTRL_BITS(CTRL_BITS), .SEL_LSB(SEL_LSB), .CH_W(CH_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .rise_i       (rise),
    .cnt_i        (cnt),
    .sdi_i        (sdi_s),
    .conv_start_i (conv_start),
    .chan_o       (conv_chan_o)
  );

  sadc_shift #(.DATA_W(DATA_W), .LEAD(LEAD), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .active_i  (active),
    .fall_i    (fall),
    .cnt_i     (cnt),
    .pos_nxt_i (pos_nxt),
    .result_i  (result_i),
    .sdo_o     (sdo_o),
    .sdo_en_o  (sdo_en_o)
  );

  a_r2_released_idle: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_en_o);
  a_r6_track_awake: assert property (@(posedge clk) disable iff (rst)
    track_o |-> !pdn_o);
  a_r5_chan_steady: assert property (@(posedge clk) disable iff (rst)
    (fall && cnt != '0 && cnt != LAST) |=> $stable(conv_chan_o));
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!sdo_en_o && !sdo_o && conv_chan_o == '0));
endmodule

// File: tb/sadc_frame_ctrl_tb.sv
module sadc_frame_ctrl_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, cs_n, sclk, sdi, corrupt;
  logic [9:0] result;
  logic       sdo, sdo_en, track, pdn;
  logic [1:0] chan;
  logic [9:0] ch_val [4];

  int n_chk = 0, n_bad = 0;
  logic [17:0] exp_q [$];
  logic [1:0]  exp_pend;
  event        smp_ev;
  int          smp_pos;
  bit          done = 0;

  always_comb result = corrupt ? ~ch_val[chan] : ch_val[chan];

  sadc_frame_ctrl u_dut (
    .clk (clk), .rst (rst), .cs_n_i (cs_n), .sclk_i (sclk), .sdi_i (sdi),
    .result_i (result), .sdo_o (sdo), .sdo_en_o (sdo_en),
    .conv_chan_o (chan), .track_o (track), .pdn_o (pdn)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwait();
    repeat (H) @(negedge clk);
  endtask

  // scoreboard monitor: assemble 16 sampled bits, compare with queued word
  initial begin
    logic [15:0] w;
    logic [17:0] e;
    w = '0;
    forever begin
      @(smp_ev);
      if (smp_pos == 1) w = '0;
      w = {w[14:0], sdo};
      if (smp_pos == 16) begin
        if (exp_q.size() == 0) begin
          check("R1 R3 unexpected word", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check("R1 R3 R5 R10 word", int'(w), int'(e[15:0]));
        end
      end
    end
  end

  task automatic idle_checks();
    check("R2 idle enable", int'(sdo_en), 0);
    check("R7 idle power-down", int'(pdn), 1);
    check("R6 idle track", int'(track), 0);
  endtask

  task automatic run_frame(input bit idle_low, input int nconv,
                           input logic [31:0] bytes, input int bad_idx);
    logic [1:0] ch;
    logic [7:0] b;
    sclk = idle_low ? 1'b0 : 1'b1;
    hwait();
    cs_n = 1'b0;
    if (!idle_low) begin
      hwait();
      check("R8 no edge while clock high", int'(track), 0);
      check("R7 powered down before first edge", int'(pdn), 1);
      sclk = 1'b0;
    end
    for (int c = 0; c < nconv; c++) begin
      b  = bytes[8*c +: 8];
      ch = exp_pend;
      exp_q.push_back({ch, 4'b0000, ch_val[ch], 2'b00});
      exp_pend = b[4:3];
      for (int n = 1; n <= 16; n++) begin
        if (n <= 8) sdi = b[8-n];
        hwait();
        smp_pos = n;
        ->smp_ev;
        check("R6 track phase", int'(track), (n <= 3) ? 1 : 0);
        check("R7 rest power-down", int'(pdn), (n == 16) ? 1 : 0);
        check("R2 enable in frame", int'(sdo_en), 1);
        if (n == 1) check("R8 first edge", int'(track), 1);
        if (n == 2) check("R5 channel", int'(chan), int'(ch));
        sclk = 1'b1;
        hwait();
        if (c == bad_idx && n == 6) corrupt = 1'b1;
        if (n == 16) corrupt = 1'b0;
        if (!(n == 16 && c == nconv - 1 && !idle_low)) sclk = 1'b0;
      end
    end
    hwait();
    cs_n = 1'b1;
    hwait();
    idle_checks();
    check("R2 data quiet", int'(sdo), 0);
  endtask

  initial begin
    ch_val[0] = 10'h2A5; ch_val[1] = 10'h15A;
    ch_val[2] = 10'h3C3; ch_val[3] = 10'h001;
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; corrupt = 1'b0;
    exp_pend = 2'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hwait();
    check("R9 reset enable", int'(sdo_en), 0);
    check("R9 reset data", int'(sdo), 0);
    check("R9 reset channel", int'(chan), 0);
    idle_checks();

    // low idle clock; byte 0xE7 has field 00 with every ignored bit set (R4)
    run_frame(1'b1, 2, {16'h0, 8'h08, 8'hE7}, -1);
    // high idle clock, three back-to-back conversions, late result change (R10)
    run_frame(1'b0, 3, {8'h0, 8'h10, 8'h00, 8'h18}, 1);
    run_frame(1'b1, 1, {24'h0, 8'h18}, -1);
    // pending channel is now input 3; reset returns it to input 0 (R9)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_pend = 2'd0;
    hwait();
    check("R9 reset mid-run channel", int'(chan), 0);
    run_frame(1'b0, 1, {24'h0, 8'hF7}, -1);
    run_frame(1'b1, 1, {24'h0, 8'h00}, -1);
    hwait();
    check("R1 all words seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule